// File: doc/BRIEF.md
# Secure Execution Mode Controller

This block holds the execution mode of a processor core: open, authenticating or secure. It also drives the protection switches that follow from that mode. The processor starts in open mode and behaves as an ordinary device there. A secure-entry request starts authentication. During authentication the debug-emulation path and DMA access to internal memory are shut off. Boundary-scan test access stays available the whole time.

While authentication runs, a hardware monitor compares the program counter every cycle with a configured firmware address window. If the program counter leaves the window, or an interrupt is taken while interrupts are enabled, the attempt is abandoned. The block then returns to open mode and gives a one-cycle abort pulse. A new secure-entry request is needed to try again. Hashing and signature checking are done elsewhere and reach this block only as pass and fail strobes. A pass grants secure mode and key-storage access. A fail returns the block to open mode. An explicit exit request leaves secure mode.

Top module: `sec_mode_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, mode_o is open (encoding 0), dbg_en_o and dma_en_o are 1, key_access_o is 0 and abort_pulse_o is 0.
- R2: In open mode, entry_req_i moves mode_o to authenticating (encoding 1) at the next clock edge, and dbg_en_o and dma_en_o go to 0 in that same cycle. entry_req_i has no effect in authenticating or secure mode.
- R3: bscan_en_o is 1 in every mode and at all times.
- R4: In authenticating mode, a program counter below win_lo_i or at or above win_hi_i returns mode_o to open at the next edge. A pc_i equal to win_lo_i is inside the window.
- R5: In authenticating mode, irq_taken_i with irq_en_i = 1 returns mode_o to open at the next edge.
- R6: In authenticating mode, irq_taken_i with irq_en_i = 0 has no effect, and the block stays authenticating.
- R7: In authenticating mode, auth_pass_i with no abort and no fail moves mode_o to secure (encoding 2). key_access_o is 1 only in secure mode.
- R8: In authenticating mode, auth_fail_i returns mode_o to open and takes priority over auth_pass_i in the same cycle. key_access_o stays 0.
- R9: abort_pulse_o is 1 for exactly one cycle after each abort (R4 or R5). An abort takes priority over a pass or fail in the same cycle. No other transition raises the pulse.
- R10: In secure mode, exit_req_i returns mode_o to open at the next edge, with dbg_en_o and dma_en_o back at 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| entry_req_i | input | 1 | Secure-entry request |
| exit_req_i | input | 1 | Leave secure mode |
| pc_i | input | PC_W | Current program counter |
| win_lo_i | input | PC_W | Firmware window start (inclusive) |
| win_hi_i | input | PC_W | Firmware window end (exclusive) |
| irq_taken_i | input | 1 | Interrupt taken this cycle |
| irq_en_i | input | 1 | Interrupts allowed during authentication |
| auth_pass_i | input | 1 | Signature check passed |
| auth_fail_i | input | 1 | Signature check failed |
| mode_o | output | 2 | 0 open, 1 authenticating, 2 secure |
| dbg_en_o | output | 1 | Debug emulation enabled |
| dma_en_o | output | 1 | DMA to internal memory enabled |
| bscan_en_o | output | 1 | Boundary-scan enabled |
| key_access_o | output | 1 | Secure key storage access granted |
| abort_pulse_o | output | 1 | One-cycle authentication abort flag |

## Verification
The pass result can arrive in the same cycle as an abort cause, either a window exit or an enabled interrupt. The correct outcome is open mode with an abort pulse, never secure mode. The bench forces this collision directly: pc_i is placed exactly at win_hi_i, or irq_taken_i is raised, in the same cycle as auth_pass_i. The random phase also produces such collisions, and a pass is sometimes paired with a fail. Every cycle is checked against a bench model that applies the priority order abort, then fail, then pass.

// File: rtl/sec_mode_pkg.sv
package sec_mode_pkg;
  typedef enum logic [1:0] {
    MODE_OPEN   = 2'd0,
    MODE_AUTH   = 2'd1,
    MODE_SECURE = 2'd2
  } sec_mode_e;
endpackage

// File: rtl/sec_pc_window.sv
module sec_pc_window #(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] lo_i,
  input  logic [PC_W-1:0] hi_i,
  output logic            in_win_o
);
  always_comb in_win_o = (pc_i >= lo_i) && (pc_i < hi_i);
endmodule

// File: rtl/sec_mode_fsm.sv
module sec_mode_fsm
  import sec_mode_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      entry_req_i,
  input  logic      exit_req_i,
  input  logic      in_win_i,
  input  logic      irq_taken_i,
  input  logic      irq_en_i,
  input  logic      auth_pass_i,
  input  logic      auth_fail_i,
  output sec_mode_e mode_o,
  output logic      abort_o
);
  sec_mode_e mode_q, mode_d;
  logic      abort_q, abort_d;
  logic      irq_hit;

  always_comb irq_hit = irq_taken_i & irq_en_i;

  // priority in auth: abort > fail > pass
  always_comb begin
    mode_d  = mode_q;
    abort_d = 1'b0;
    unique case (mode_q)
      MODE_OPEN:   if (entry_req_i) mode_d = MODE_AUTH;
      MODE_AUTH: begin
        if (!in_win_i || irq_hit) begin
          mode_d  = MODE_OPEN;
          abort_d = 1'b1;
        end else if (auth_fail_i) begin
          mode_d = MODE_OPEN;
        end else if (auth_pass_i) begin
          mode_d = MODE_SECURE;
        end
      end
      MODE_SECURE: if (exit_req_i) mode_d = MODE_OPEN;
      default:     mode_d = MODE_OPEN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_OPEN;
      abort_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      abort_q <= abort_d;
    end
  end

  assign mode_o  = mode_q;
  assign abort_o = abort_q;
endmodule

// File: rtl/sec_switch_map.sv
module sec_switch_map
  import sec_mode_pkg::*;
(
  input  sec_mode_e mode_i,
  output logic      dbg_en_o,
  output logic      dma_en_o,
  output logic      bscan_en_o,
  output logic      key_access_o
);
  always_comb begin
    dbg_en_o     = (mode_i == MODE_OPEN);
    dma_en_o     = (mode_i == MODE_OPEN);
    bscan_en_o   = 1'b1;
    key_access_o = (mode_i == MODE_SECURE);
  end
endmodule

// File: rtl/sec_mode_ctrl.sv
module sec_mode_ctrl
  import sec_mode_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            entry_req_i,
  input  logic            exit_req_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] win_lo_i,
  input  logic [PC_W-1:0] win_hi_i,
  input  logic            irq_taken_i,
  input  logic            irq_en_i,
  input  logic            auth_pass_i,
  input  logic            auth_fail_i,
  output logic [1:0]      mode_o,
  output logic            dbg_en_o,
  output logic            dma_en_o,
  output logic            bscan_en_o,
  output logic            key_access_o,
  output logic            abort_pulse_o
);
  logic      in_win;
  sec_mode_e mode;

  sec_pc_window #(.PC_W(PC_W)) u_win (
    .pc_i    (pc_i),
    .lo_i    (win_lo_i),
    .hi_i    (win_hi_i),
    .in_win_o(in_win)
  );

  sec_mode_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .entry_req_i(entry_req_i),
    .exit_req_i (exit_req_i),
    .in_win_i   (in_win),
    .irq_taken_i(irq_taken_i),
    .irq_en_i   (irq_en_i),
    .auth_pass_i(auth_pass_i),
    .auth_fail_i(auth_fail_i),
    .mode_o     (mode),
    .abort_o    (abort_pulse_o)
  );

  sec_switch_map u_sw (
    .mode_i      (mode),
    .dbg_en_o    (dbg_en_o),
    .dma_en_o    (dma_en_o),
    .bscan_en_o  (bscan_en_o),
    .key_access_o(key_access_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/sec_mode_ctrl_chk.sv
module sec_mode_ctrl_chk #(
  parameter int PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            entry_req_i,
  input logic            exit_req_i,
  input logic [PC_W-1:0] pc_i,
  input logic [PC_W-1:0] win_lo_i,
  input logic [PC_W-1:0] win_hi_i,
  input logic            irq_taken_i,
  input logic            irq_en_i,
  input logic            auth_pass_i,
  input logic            auth_fail_i,
  input logic [1:0]      mode_o,
  input logic            dbg_en_o,
  input logic            dma_en_o,
  input logic            bscan_en_o,
  input logic            key_access_o,
  input logic            abort_pulse_o
);
  logic in_auth, out_win, irq_abort;
  assign in_auth   = (mode_o == 2'd1);
  assign out_win   = (pc_i < win_lo_i) || (pc_i >= win_hi_i);
  assign irq_abort = irq_taken_i && irq_en_i;

  p_reset_open_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (mode_o == 2'd0) && dbg_en_o && dma_en_o && !key_access_o && !abort_pulse_o);

  p_entry_locks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0) && entry_req_i |=> in_auth && !dbg_en_o && !dma_en_o);

  p_bscan_on_r3: assert property (@(posedge clk_i) disable iff (!rst_ni) bscan_en_o);

  p_window_abort_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_auth && out_win |=> (mode_o == 2'd0) && abort_pulse_o);

  p_irq_abort_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_auth && irq_abort |=> (mode_o == 2'd0) && abort_pulse_o);

  p_irq_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_auth && irq_taken_i && !irq_en_i && !out_win && !auth_pass_i && !auth_fail_i |=> in_auth);

  p_pass_secure_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_auth && auth_pass_i && !auth_fail_i && !out_win && !irq_abort |=> (mode_o == 2'd2));

  p_key_only_secure_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_access_o |-> (mode_o == 2'd2));

  p_fail_open_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_auth && auth_fail_i |=> (mode_o == 2'd0) && !key_access_o);

  p_abort_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_pulse_o |=> !abort_pulse_o);

  p_abort_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_auth && (out_win || irq_abort)) |=> !abort_pulse_o);

  p_exit_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2) && exit_req_i |=> (mode_o == 2'd0) && dbg_en_o && dma_en_o);
endmodule

bind sec_mode_ctrl sec_mode_ctrl_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/sec_mode_ctrl_bench.sv
module sec_mode_ctrl_bench;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            entry_req = 1'b0, exit_req = 1'b0;
  logic [PC_W-1:0] pc = '0, win_lo = 32'h100, win_hi = 32'h200;
  logic            irq_taken = 1'b0, irq_en = 1'b1, auth_pass = 1'b0, auth_fail = 1'b0;
  logic [1:0]      mode;
  logic            dbg_en, dma_en, bscan_en, key_access, abort_pulse;

  int    n_checks = 0, n_fail = 0, cyc = 0;
  bit    done = 0;
  logic [1:0] exp_mode = 2'd0;
  logic       exp_abort = 1'b0;
  string      exp_tag = "R1";

  always #2 clk = ~clk;

  sec_mode_ctrl #(.PC_W(PC_W)) u_sec_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .entry_req_i(entry_req), .exit_req_i(exit_req),
    .pc_i(pc), .win_lo_i(win_lo), .win_hi_i(win_hi), .irq_taken_i(irq_taken),
    .irq_en_i(irq_en), .auth_pass_i(auth_pass), .auth_fail_i(auth_fail),
    .mode_o(mode), .dbg_en_o(dbg_en), .dma_en_o(dma_en), .bscan_en_o(bscan_en),
    .key_access_o(key_access), .abort_pulse_o(abort_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_sw(input logic [1:0] m);
    // {dbg, dma, bscan, key}
    return {m == 2'd0, m == 2'd0, 1'b1, m == 2'd2};
  endfunction

  task automatic check_outputs();
    chk(mode == exp_mode, exp_tag, mode, exp_mode);
    chk(abort_pulse == exp_abort, "R9 abort pulse", abort_pulse, exp_abort);
    chk(bscan_en == 1'b1, "R3 bscan", bscan_en, 1);
    chk({dbg_en, dma_en, bscan_en, key_access} == exp_sw(exp_mode),
        (exp_mode == 2'd2) ? "R7 switches" : (exp_mode == 2'd1) ? "R2 switches" : "R10 switches",
        {dbg_en, dma_en, bscan_en, key_access}, exp_sw(exp_mode));
  endtask

  task automatic model();
    logic ow;
    ow = (pc < win_lo) || (pc >= win_hi);
    exp_abort = 1'b0;
    case (exp_mode)
      2'd0: begin exp_tag = "R2 entry"; if (entry_req) exp_mode = 2'd1; end
      2'd1: begin
        if (ow) begin exp_mode = 2'd0; exp_abort = 1'b1; exp_tag = "R4 window"; end
        else if (irq_taken && irq_en) begin exp_mode = 2'd0; exp_abort = 1'b1; exp_tag = "R5 irq"; end
        else if (auth_fail) begin exp_mode = 2'd0; exp_tag = "R8 fail"; end
        else if (auth_pass) begin exp_mode = 2'd2; exp_tag = "R7 pass"; end
        else exp_tag = irq_taken ? "R6 masked irq" : "R4 hold";
      end
      default: begin exp_tag = "R10 exit"; if (exit_req) exp_mode = 2'd0; end
    endcase
  endtask

  task automatic step(input logic e, input logic x, input logic [PC_W-1:0] p,
                      input logic it, input logic ie, input logic ps, input logic fl);
    @(negedge clk);
    check_outputs();
    entry_req = e; exit_req = x; pc = p; irq_taken = it; irq_en = ie;
    auth_pass = ps; auth_fail = fl;
    model();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 32'h180, 0, 1, 0, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    chk(mode == 2'd0 && dbg_en && dma_en && !key_access, "R1 in reset", mode, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    pc = 32'h180;
    idle(2);
    // R2/R7: enter and pass
    step(1, 0, 32'h180, 0, 1, 0, 0);
    step(0, 0, 32'h100, 0, 1, 0, 0);        // R4 lower bound inclusive
    step(1, 0, 32'h1ff, 0, 1, 1, 0);        // R2 entry ignored, pass
    step(1, 0, 32'h180, 0, 1, 0, 0);        // R2 entry ignored in secure
    step(0, 1, 32'h180, 0, 1, 0, 0);        // R10 exit
    idle(1);
    // R9: pass collides with pc at upper bound
    step(1, 0, 32'h180, 0, 1, 0, 0);
    step(0, 0, 32'h200, 0, 1, 1, 0);
    idle(2);
    // R5/R9: irq with pass
    step(1, 0, 32'h180, 0, 1, 0, 0);
    step(0, 0, 32'h180, 1, 1, 1, 0);
    idle(1);
    // R6: masked irq, then R8 fail over pass
    step(1, 0, 32'h180, 0, 0, 0, 0);
    step(0, 0, 32'h180, 1, 0, 0, 0);
    step(0, 0, 32'h180, 0, 0, 1, 1);
    idle(1);
    // R4 below window
    step(1, 0, 32'h180, 0, 1, 0, 0);
    step(0, 0, 32'h0ff, 0, 1, 0, 0);
    idle(1);
    // R1: asynchronous reset in authenticating mode
    step(1, 0, 32'h180, 0, 1, 0, 0);
    step(0, 0, 32'h180, 0, 1, 0, 0);
    @(negedge clk);
    check_outputs();
    rst_ni = 1'b0;
    #1;
    chk(mode == 2'd0 && dbg_en && dma_en && !abort_pulse, "R1 async reset", mode, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    exp_mode = 2'd0; exp_abort = 1'b0; exp_tag = "R1 after reset";
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [PC_W-1:0] p;
      int r;
      r = $urandom_range(99);
      p = (r < 8) ? ((r < 4) ? 32'h200 + $urandom_range(64) : $urandom_range(32'h100))
                  : 32'h100 + $urandom_range(32'hff);
      step($urandom_range(99) < 30, $urandom_range(99) < 15, p,
           $urandom_range(99) < 10, $urandom_range(99) < 70,
           $urandom_range(99) < 12, $urandom_range(99) < 8);
    end
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule